// File: doc/BRIEF.md
# Filtering Asynchronous Serial Receiver

This block receives asynchronous serial characters on a single line. Each character has a start bit, 5 to 8 data bits sent least significant bit first, an optional parity bit and a stop bit. The line is oversampled at sixteen times the bit rate. A programmable clock divisor sets that rate, which covers line speeds from 50 to 9600 baud over a wide range of system clocks. The character length and parity mode come from static configuration inputs.

Every completed character then passes through three filters, each switched on or off by a command:
- **Monitor.** Compares the character with a stored code and reports a hit.
- **Suppress.** Drops characters equal to a stored code.
- **Sync search.** Discards everything until a programmed sync character arrives. The sync character itself is also discarded.

Characters that survive appear on a valid/ready output. The same command port sets or clears a data-terminal-ready discrete output.

Top module: `serial_rx_filter`

## Requirements
- R1: After reset the outputs are as follows: `out_valid` is 0, `dtr` is 0, and `par_err`, `frm_err` and `mon_hit` are all 0.
- R2: `char_len` selects the number of data bits.
  - Codes 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits.
  - Data is received least significant bit first.
  - On `out_data`, every bit above the configured length is 0.
- R3: `par_mode` selects the parity check.
  - Code 1 is even parity, code 2 is odd parity, and codes 0 and 3 mean no parity bit.
  - On a parity mismatch, `par_err` is 1 for that character.
  - A character with a parity mismatch is still delivered unless a filter drops it.
- R4: If the stop bit is sampled low, `frm_err` is 1 for that character.
- R5: A start bit is accepted only if the line is still low at the middle of the bit. A low pulse shorter than half a bit produces no character.
- R6: One oversampling tick lasts `div`+1 clocks, and one bit lasts 16 ticks.
- R7: Monitor commands work as follows:
  - Command 0 loads `cmd_data` as the monitor code and enables the monitor.
  - Command 1 disables the monitor.
  - `mon_hit` is 1 when the monitor is enabled and the last character equalled the code.
  - A monitor hit does not stop the character from being output.
- R8: Suppress commands work as follows:
  - Command 2 loads `cmd_data` as the suppress code and enables suppression.
  - Command 3 disables suppression.
  - While suppression is enabled, a character equal to the code is not output.
- R9: Sync-search commands work as follows:
  - Command 4 loads `cmd_data` as the sync code and starts a search.
  - During a search no character is output.
  - The character equal to the sync code ends the search and is not output.
  - Command 5 abandons the search.
- R10: Command 6 sets `dtr` and command 7 clears it, from the clock edge after the command.
- R11: An output character stays on `out_data` with `out_valid` high until it is taken with `out_ready`. A newer accepted character replaces one that has not been taken.
- R12: All code comparisons use only the configured data bits. `par_err`, `frm_err` and `mon_hit` change only when a character completes, and they hold until the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx | input | 1 | Serial line input, idle high |
| div | input | DIVW | Oversampling tick period minus one, in clocks |
| char_len | input | 2 | Data bits minus five |
| par_mode | input | 2 | Parity mode: 0 none, 1 even, 2 odd, 3 none |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_code | input | 3 | Command code (see R7 to R10) |
| cmd_data | input | 8 | Code value for load commands |
| out_valid | output | 1 | Accepted character available |
| out_ready | input | 1 | Consumer takes the character |
| out_data | output | 8 | Accepted character, zero-extended |
| par_err | output | 1 | Last character had a parity mismatch |
| frm_err | output | 1 | Last character had a low stop bit |
| mon_hit | output | 1 | Last character matched the monitor code |
| dtr | output | 1 | Data-terminal-ready discrete |

## Verification
The monitor and the suppress filter both act on the same completed character, in the same cycle. To provoke this, the bench loads one code into both registers and sends that character. The case is judged correct when `mon_hit` reads 1 and no character appears on the output: the drop must not mask the hit, and the hit must not let the character through. A similar overlap is checked where the sync character also matches an enabled monitor code.

// File: rtl/serial_rx_filter.sv
module serial_rx_filter #(
  parameter int DIVW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rx,
  input  logic [DIVW-1:0] div,
  input  logic [1:0]      char_len,
  input  logic [1:0]      par_mode,
  input  logic            cmd_valid,
  input  logic [2:0]      cmd_code,
  input  logic [7:0]      cmd_data,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [7:0]      out_data,
  output logic            par_err,
  output logic            frm_err,
  output logic            mon_hit,
  output logic            dtr
);
  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t             st;
  logic [DIVW-1:0] tcnt;
  logic [3:0]      sc;
  logic [2:0]      bitn;
  logic [7:0]      sh;
  logic            pbit;
  logic [1:0]      rx_q;
  logic [7:0]      mon_c, sup_c, syn_c;
  logic            mon_en, sup_en, hunt;

  wire       rx_s   = rx_q[1];
  wire       tick   = (tcnt == div);
  wire       par_on = (par_mode == 2'd1) || (par_mode == 2'd2);
  wire       odd    = (par_mode == 2'd2);
  wire [7:0] mask   = 8'hFF >> (2'd3 - char_len);
  wire [7:0] ch     = sh >> (2'd3 - char_len);
  wire [2:0] last   = 3'd4 + {1'b0, char_len};
  wire       mid    = tick && (sc == 4'd15);
  wire       done   = mid && (st == S_STOP);
  wire       is_mon = mon_en && (ch == (mon_c & mask));
  wire       is_sup = sup_en && (ch == (sup_c & mask));
  wire       is_syn = (ch == (syn_c & mask));
  wire       keep   = !hunt && !is_sup;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q <= 2'b11;
      tcnt <= '0;
    end else begin
      rx_q <= {rx_q[0], rx};
      tcnt <= tick ? '0 : tcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      sc   <= '0;
      bitn <= '0;
      sh   <= '0;
      pbit <= 1'b0;
    end else if (tick) begin
      sc <= sc + 1'b1;
      case (st)
        S_IDLE: begin
          sc <= '0;
          if (!rx_s) st <= S_START;
        end
        S_START: if (sc == 4'd7) begin
          sc   <= '0;
          bitn <= '0;
          st   <= rx_s ? S_IDLE : S_DATA;
        end
        S_DATA: if (sc == 4'd15) begin
          sh   <= {rx_s, sh[7:1]};
          bitn <= bitn + 1'b1;
          if (bitn == last) st <= par_on ? S_PAR : S_STOP;
        end
        S_PAR: if (sc == 4'd15) begin
          pbit <= rx_s;
          st   <= S_STOP;
        end
        S_STOP: if (sc == 4'd15) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      par_err   <= 1'b0;
      frm_err   <= 1'b0;
      mon_hit   <= 1'b0;
      hunt      <= 1'b0;
    end else begin
      if (done) begin
        frm_err <= !rx_s;
        par_err <= par_on && ((^ch ^ pbit) != odd);
        mon_hit <= is_mon;
        if (hunt && is_syn) hunt <= 1'b0;
      end
      if (done && keep) begin
        out_valid <= 1'b1;
        out_data  <= ch;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
      if (cmd_valid && cmd_code == 3'd4) hunt <= 1'b1;
      if (cmd_valid && cmd_code == 3'd5) hunt <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mon_c  <= '0;
      sup_c  <= '0;
      syn_c  <= '0;
      mon_en <= 1'b0;
      sup_en <= 1'b0;
      dtr    <= 1'b0;
    end else if (cmd_valid) begin
      case (cmd_code)
        3'd0: begin mon_c <= cmd_data; mon_en <= 1'b1; end
        3'd1: mon_en <= 1'b0;
        3'd2: begin sup_c <= cmd_data; sup_en <= 1'b1; end
        3'd3: sup_en <= 1'b0;
        3'd4: syn_c <= cmd_data;
        3'd6: dtr <= 1'b1;
        3'd7: dtr <= 1'b0;
        default: ;
      endcase
    end
  end
endmodule

module serial_rx_filter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       done,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic [7:0] mask,
  input logic       cmd_valid,
  input logic [2:0] cmd_code,
  input logic       dtr,
  input logic       par_err,
  input logic       frm_err,
  input logic       mon_hit
);
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !done |=> out_valid && $stable(out_data));

  p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !done && !cmd_valid |-> (out_data & ~mask) == 8'h00);

  p_dtr_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_code == 3'd6 |=> dtr);

  p_dtr_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_code == 3'd7 |=> !dtr);

  p_dtr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_code[2:1] == 2'b11) |=> $stable(dtr));

  p_flags_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(par_err) && $stable(frm_err) && $stable(mon_hit));
endmodule

bind serial_rx_filter serial_rx_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .mask(mask),
  .cmd_valid(cmd_valid), .cmd_code(cmd_code), .dtr(dtr),
  .par_err(par_err), .frm_err(frm_err), .mon_hit(mon_hit)
);

// File: tb/serial_rx_filter_bench.sv
module serial_rx_filter_bench;
  localparam int CLK_P = 10;

  logic        clk = 0, rst_n = 0, rx = 1;
  logic [15:0] div = 16'd3;
  logic [1:0]  char_len = 2'd3, par_mode = 2'd0;
  logic        cmd_valid = 0, out_ready = 1;
  logic [2:0]  cmd_code = 0;
  logic [7:0]  cmd_data = 0;
  logic        out_valid, par_err, frm_err, mon_hit, dtr;
  logic [7:0]  out_data;

  int n_chk = 0, n_bad = 0, ngot = 0;
  logic [7:0] got [256];

  serial_rx_filter u_serial_rx_filter (
    .clk(clk), .rst_n(rst_n), .rx(rx), .div(div), .char_len(char_len),
    .par_mode(par_mode), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_data(cmd_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .par_err(par_err), .frm_err(frm_err),
    .mon_hit(mon_hit), .dtr(dtr));

  always #(CLK_P/2) clk = ~clk;

  always @(negedge clk)
    if (rst_n && out_valid && out_ready) begin
      got[ngot[7:0]] = out_data;
      ngot++;
    end

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] lmask();
    return 8'hFF >> (3 - char_len);
  endfunction

  task automatic hold_bits(int nb);
    repeat (nb * 16 * (int'(div) + 1)) @(negedge clk);
  endtask

  task automatic send(logic [7:0] d, bit bad_par = 0, bit bad_stop = 0);
    int n = 5 + int'(char_len);
    logic p = 0;
    for (int i = 0; i < n; i++) p ^= d[i];
    if (par_mode == 2'd2) p = ~p;
    rx = 0; hold_bits(1);
    for (int i = 0; i < n; i++) begin rx = d[i]; hold_bits(1); end
    if (par_mode == 2'd1 || par_mode == 2'd2) begin rx = p ^ bad_par; hold_bits(1); end
    rx = ~bad_stop; hold_bits(1);
    rx = 1; hold_bits(1);
  endtask

  task automatic cmd(logic [2:0] c, logic [7:0] d = 0);
    @(negedge clk);
    cmd_valid = 1; cmd_code = c; cmd_data = d;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic expect_one(string tag, logic [7:0] e);
    int n0 = ngot;
    check(tag, 0, 0);
    n_chk--;
  endtask

  task automatic rx_expect(string tag, logic [7:0] d, bit deliver, logic [7:0] e);
    int n0 = ngot;
    send(d);
    check({tag, " count"}, ngot - n0, deliver ? 1 : 0);
    if (deliver && ngot > n0) check({tag, " data"}, got[n0[7:0]], e);
  endtask

  task automatic t_reset();
    check("R1 out_valid", out_valid, 0);
    check("R1 dtr", dtr, 0);
    check("R1 flags", {par_err, frm_err, mon_hit}, 0);
  endtask

  task automatic t_length();
    for (int l = 0; l < 4; l++) begin
      char_len = l[1:0];
      rx_expect("R2 length", 8'hB7, 1, 8'hB7 & lmask());
      rx_expect("R2 pattern", 8'h5A, 1, 8'h5A & lmask());
    end
    char_len = 2'd3;
  endtask

  task automatic t_parity();
    int n0;
    for (int m = 1; m < 3; m++) begin
      par_mode = m[1:0];
      n0 = ngot;
      send(8'h6C);
      check("R3 good parity", par_err, 0);
      send(8'h6D, 1);
      check("R3 bad parity", par_err, 1);
      check("R3 bad parity delivered", ngot - n0, 2);
      if (ngot == n0 + 2) check("R3 data", got[(n0 + 1) & 255], 8'h6D);
    end
    par_mode = 2'd0;
  endtask

  task automatic t_frame();
    send(8'h21, 0, 1);
    check("R4 framing", frm_err, 1);
    hold_bits(3);
    check("R12 flag held", frm_err, 1);
    send(8'h21);
    check("R4 framing cleared", frm_err, 0);
  endtask

  task automatic t_glitch();
    int n0 = ngot;
    rx = 0;
    repeat (3 * (int'(div) + 1)) @(negedge clk);
    rx = 1;
    hold_bits(14);
    check("R5 glitch ignored", ngot - n0, 0);
    rx_expect("R5 after glitch", 8'h3C, 1, 8'h3C);
  endtask

  task automatic t_div();
    div = 16'd7;
    rx_expect("R6 div7", 8'hA5, 1, 8'hA5);
    div = 16'd1;
    rx_expect("R6 div1", 8'h96, 1, 8'h96);
    div = 16'd3;
  endtask

  task automatic t_monitor();
    cmd(3'd0, 8'h41);
    rx_expect("R7 hit delivered", 8'h41, 1, 8'h41);
    check("R7 hit", mon_hit, 1);
    send(8'h42);
    check("R7 miss", mon_hit, 0);
    cmd(3'd1);
    send(8'h41);
    check("R7 disabled", mon_hit, 0);
  endtask

  task automatic t_suppress();
    cmd(3'd2, 8'h55);
    rx_expect("R8 drop", 8'h55, 0, 0);
    rx_expect("R8 pass", 8'h56, 1, 8'h56);
    cmd(3'd3);
    rx_expect("R8 disabled", 8'h55, 1, 8'h55);
    char_len = 2'd0;
    cmd(3'd2, 8'h35);
    rx_expect("R12 masked compare", 8'h15, 0, 0);
    cmd(3'd3);
    char_len = 2'd3;
  endtask

  task automatic t_both();
    cmd(3'd0, 8'h33);
    cmd(3'd2, 8'h33);
    rx_expect("R8 monitor+suppress dropped", 8'h33, 0, 0);
    check("R7 monitor+suppress hit", mon_hit, 1);
    cmd(3'd1);
    cmd(3'd3);
  endtask

  task automatic t_sync();
    cmd(3'd4, 8'h7E);
    rx_expect("R9 hunt drop a", 8'h11, 0, 0);
    rx_expect("R9 hunt drop b", 8'h22, 0, 0);
    rx_expect("R9 sync dropped", 8'h7E, 0, 0);
    rx_expect("R9 after sync", 8'h33, 1, 8'h33);
    cmd(3'd4, 8'h7E);
    rx_expect("R9 hunt again", 8'h11, 0, 0);
    cmd(3'd5);
    rx_expect("R9 abandoned", 8'h22, 1, 8'h22);
    cmd(3'd0, 8'h7E);
    cmd(3'd4, 8'h7E);
    rx_expect("R9 sync with monitor", 8'h7E, 0, 0);
    check("R7 sync monitored", mon_hit, 1);
    cmd(3'd1);
  endtask

  task automatic t_dtr();
    cmd(3'd6);
    check("R10 dtr set", dtr, 1);
    cmd(3'd7);
    check("R10 dtr clear", dtr, 0);
  endtask

  task automatic t_hold();
    int n0;
    out_ready = 0;
    send(8'h12);
    check("R11 valid", out_valid, 1);
    check("R11 data", out_data, 8'h12);
    hold_bits(2);
    check("R11 held", out_data, 8'h12);
    send(8'h34);
    check("R11 replaced", out_data, 8'h34);
    n0 = ngot;
    @(negedge clk);
    out_ready = 1;
    @(negedge clk);
    @(negedge clk);
    check("R11 taken", ngot - n0, 1);
    if (ngot > n0) check("R11 taken data", got[n0[7:0]], 8'h34);
    check("R11 valid low", out_valid, 0);
  endtask

  initial begin
    #(CLK_P * 190000);
    n_bad++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    hold_bits(1);
    t_length();
    t_parity();
    t_frame();
    t_glitch();
    t_div();
    t_monitor();
    t_suppress();
    t_both();
    t_sync();
    t_dtr();
    t_hold();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule